// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a Clause-22 management master for an Ethernet PHY. The host controls it through one 32-bit command word. The same word carries the transaction fields, a start/busy flag, a read-failure flag and the 16-bit data. The host loads the opcode, PHY address, register address and, for a write, the data. It then sets the start bit. The block derives the management clock from the system clock and shifts out a full management frame. It clears the busy flag when the frame ends.

For a read, the controller releases the data line at the turnaround. It samples the PHY's reply on the rising clock edges and places the 16 received bits in the low half of the command word. If the PHY does not pull the second turnaround bit low, the controller sets a sticky failure flag. The host finds out that a transaction has finished by polling the busy flag.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads zero, MDC is low and the MDIO output enable is low.
- R2: A host write with bit 29 clear stores bits 28:0 unchanged and reads them back. Bits 31:30 always read zero, and no frame is started.
- R3: A host write with bit 29 set starts a frame only if bits 27:26 hold 01 (write) or 10 (read). With 00 or 11 the fields are stored but busy (bit 29) stays 0 and MDC stays low.
- R4: A host write while busy is set is ignored. The opcode, address and data fields and the frame in progress are unchanged.
- R5: MDC is low whenever the block is idle. During a frame it has a period of 2*DIV_HALF system cycles.
- R6: A frame is PRE_LEN ones, then start bits 01, the opcode (bits 27:26), PHY address (bits 25:21), register address (bits 20:16), a two-bit turnaround (10 for writes) and data bits 15:0, all MSB first. MDIO changes only on MDC falling edges.
- R7: The output enable is high for every bit of a write frame. In a read frame it is high only before the first turnaround bit and stays low from there to the end. It is low when idle.
- R8: Busy stays set for exactly (PRE_LEN+32)*2*DIV_HALF system cycles after the start write is accepted. After a write frame the data field is unchanged.
- R9: When a read completes, bits 15:0 hold the 16 bits sampled from the PHY on MDC rising edges, first sample in bit 15.
- R10: Bit 28 is set at the end of a read whose second turnaround bit is sampled high. Hardware never clears it. Only an accepted host write replaces it with the written bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by the host |
| cmd_rdata | output | 32 | Current command word: busy, fail, fields and data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high = controller drives the line) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
A bit-position counter that goes wrong shows up within one MDC period. A shifted or corrupted header bit appears on MDIO at the next rising edge. The busy flag clears early or late, which shows as a cycle-count error in the polling loop. A turnaround or capture error stays hidden until the read finishes. It then appears as a data word rotated by one bit, or as a wrong failure flag in the command word, about one frame time after launch. An acceptance error while busy corrupts the fields that are read back at once, and the next frame's header carries the same damage.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
   localparam int BUSY_BIT = 29;
   localparam int FAIL_BIT = 28;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;

   typedef struct packed {
      logic [1:0]  op;
      logic [4:0]  phy;
      logic [4:0]  regad;
      logic [15:0] data;
   } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   logic tick;

   generate
      if (DIV_HALF == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int CW = $clog2(DIV_HALF);
         logic [CW-1:0] cnt;
         assign tick = run && (cnt == CW'(DIV_HALF - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !run || tick) cnt <= '0;
            else                        cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) mdc <= 1'b0;
      else if (tick)      mdc <= ~mdc;
   end

   assign rise_tick = tick & ~mdc;
   assign fall_tick = tick & mdc;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_cmd_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        launch,
   input  mdio_cmd_t   cmd,
   input  logic        rise_tick,
   input  logic        fall_tick,
   input  logic        mdio_i,
   output logic        active,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        ta_fail
);
   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int IW        = $clog2(FRAME_LEN);
   localparam int TA1       = PRE_LEN + 14;
   localparam int TA2       = PRE_LEN + 15;
   localparam int DAT0      = PRE_LEN + 16;
   localparam int LAST      = FRAME_LEN - 1;

   logic [IW-1:0] idx;
   logic [31:0]   tail;
   logic [4:0]    tpos;
   logic          cur_bit;
   logic          is_rd;
   logic [15:0]   shreg;
   logic          ta_bad;

   assign is_rd = (cmd.op == OPC_READ);
   assign tail  = {2'b01, cmd.op, cmd.phy, cmd.regad, 2'b10, cmd.data};

   always_comb begin
      tpos = 5'(idx - IW'(PRE_LEN));
      if (idx < IW'(PRE_LEN)) cur_bit = 1'b1;
      else                    cur_bit = tail[~tpos];
   end

   assign mdio_o  = active ? cur_bit : 1'b1;
   assign mdio_oe = active && (!is_rd || (idx < IW'(TA1)));
   assign done    = active && fall_tick && (idx == IW'(LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         shreg  <= '0;
         ta_bad <= 1'b0;
      end else if (launch) begin
         active <= 1'b1;
         idx    <= '0;
         ta_bad <= 1'b0;
      end else if (active) begin
         if (fall_tick) begin
            if (idx == IW'(LAST)) active <= 1'b0;
            else                  idx    <= idx + 1'b1;
         end
         if (rise_tick && is_rd) begin
            if (idx == IW'(TA2))  ta_bad <= mdio_i;
            if (idx >= IW'(DAT0)) shreg  <= {shreg[14:0], mdio_i};
         end
      end
   end

   assign rd_data = shreg;
   assign ta_fail = ta_bad;
endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
   import mdio_cmd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [29:0] wdata,
   input  logic        done,
   input  logic [15:0] rd_data,
   input  logic        ta_fail,
   output logic [31:0] rdata,
   output mdio_cmd_t   cmd,
   output logic        launch
);
   logic busy;
   logic fail;
   logic accept;
   logic op_ok;

   assign accept = wr && !busy;
   assign op_ok  = (wdata[27:26] == OPC_WRITE) || (wdata[27:26] == OPC_READ);
   assign launch = accept && wdata[BUSY_BIT] && op_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         fail <= 1'b0;
         cmd  <= '0;
      end else if (accept) begin
         cmd  <= wdata[27:0];
         fail <= wdata[FAIL_BIT];
         busy <= launch;
      end else if (done) begin
         busy <= 1'b0;
         if (cmd.op == OPC_READ) begin
            cmd.data <= rd_data;
            if (ta_fail) fail <= 1'b1;
         end
      end
   end

   assign rdata = {2'b00, busy, fail, cmd};
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
   import mdio_cmd_pkg::*;
#(
   parameter int DIV_HALF = 2,
   parameter int PRE_LEN  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [31:0] cmd_wdata,
   output logic [31:0] cmd_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..64");
      end
   endgenerate

   mdio_cmd_t   cmd;
   logic        launch;
   logic        active;
   logic        rise_tick;
   logic        fall_tick;
   logic        done;
   logic [15:0] rd_data;
   logic        ta_fail;
   logic        wdata_hi_unused;

   assign wdata_hi_unused = ^cmd_wdata[31:30];

   mdio_cmd_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cmd_wr),
      .wdata   (cmd_wdata[29:0]),
      .done    (done),
      .rd_data (rd_data),
      .ta_fail (ta_fail),
      .rdata   (cmd_rdata),
      .cmd     (cmd),
      .launch  (launch)
   );

   mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (active),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .cmd       (cmd),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .active    (active),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .done      (done),
      .rd_data   (rd_data),
      .ta_fail   (ta_fail)
   );
endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_wr,
   input logic        wd_start,
   input logic [1:0]  wd_op,
   input logic        busy,
   input logic        fail,
   input logic [11:0] hdr,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);
   AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc); // R5

   AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe); // R7

   AST_OE_NO_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !$rose(mdio_oe)); // R7

   AST_BAD_OP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy && wd_start && (wd_op == 2'b00 || wd_op == 2'b11)) |=> !busy); // R3

   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> (hdr == $past(hdr))); // R4

   AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o)); // R6

   AST_FAIL_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> ($past(busy) || $past(cmd_wr))); // R10
endmodule

bind mdio_cmd_ctrl mdio_cmd_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_wr   (cmd_wr),
   .wd_start (cmd_wdata[29]),
   .wd_op    (cmd_wdata[27:26]),
   .busy     (cmd_rdata[29]),
   .fail     (cmd_rdata[28]),
   .hdr      (cmd_rdata[27:16]),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe)
);

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb;
   localparam int CLK_P    = 10;
   localparam int DIV_HALF = 2;
   localparam int PRE_LEN  = 32;
   localparam int FRAME    = PRE_LEN + 32;
   localparam int TA1      = PRE_LEN + 14;
   localparam int TA2      = PRE_LEN + 15;
   localparam int DAT0     = PRE_LEN + 16;
   localparam int BUSY_CYC = FRAME * 2 * DIV_HALF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   int          k = 0;
   logic        cap_o  [0:127];
   logic        cap_oe [0:127];
   time         rise_t [0:127];
   logic        ta_val = 1'b0;
   logic [15:0] resp = '0;

   always #(CLK_P/2) clk = ~clk;

   mdio_cmd_ctrl #(.DIV_HALF(DIV_HALF), .PRE_LEN(PRE_LEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   // PHY model: records each bit at the MDC rising edge, answers reads on falling edges
   always @(posedge mdc) begin
      if (k < 128) begin
         cap_o[k]  = mdio_o;
         cap_oe[k] = mdio_oe;
         rise_t[k] = $time;
      end
      k = k + 1;
   end

   always @(negedge mdc) begin
      if (k == TA2)                    mdio_i = ta_val;
      else if (k >= DAT0 && k < FRAME) mdio_i = resp[15 - (k - DAT0)];
      else                             mdio_i = 1'b1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit st, input bit fl, input logic [1:0] op,
                                      input logic [4:0] phy, input logic [4:0] rg,
                                      input logic [15:0] d);
      return {2'b00, st, fl, op, phy, rg, d};
   endfunction

   task automatic host_write(input logic [31:0] w);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_wdata = w;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (cmd_rdata[29] && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic chk_header(input string req, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] d, input int upto);
      logic [31:0] tail;
      int bad = 0;
      int first = -1;
      logic e;
      tail = {2'b01, op, phy, rg, 2'b10, d};
      for (int i = 0; i < upto; i++) begin
         e = (i < PRE_LEN) ? 1'b1 : tail[31 - (i - PRE_LEN)];
         if (cap_o[i] !== e) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      chk(req, 32'(first), 32'hFFFF_FFFF);
      chk(req, 32'(k), 32'(FRAME));
   endtask

   task automatic t_reset();
      chk("R1 cmd word", cmd_rdata, 32'h0);
      chk("R1 mdc", {31'd0, mdc}, 32'd0);
      chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
   endtask

   task automatic t_fields();
      bit saw_mdc = 0;
      host_write(32'h1ABC_1234);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mdc) saw_mdc = 1;
      end
      chk("R2 readback", cmd_rdata, 32'h1ABC_1234);
      chk("R2 no clock", {31'd0, saw_mdc}, 32'd0);
      host_write(32'hC000_0000);
      chk("R2 top bits", cmd_rdata, 32'h0);
   endtask

   task automatic t_bad_op();
      bit saw_mdc = 0;
      host_write(mk(1, 0, 2'b00, 5'h02, 5'h03, 16'h0F0F));
      host_write(mk(1, 0, 2'b11, 5'h04, 5'h05, 16'hF0F0));
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mdc || cmd_rdata[29]) saw_mdc = 1;
      end
      chk("R3 no launch", {31'd0, saw_mdc}, 32'd0);
      chk("R3 fields kept", cmd_rdata, mk(0, 0, 2'b11, 5'h04, 5'h05, 16'hF0F0));
   endtask

   task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d,
                          input bit try_ignore);
      int n;
      int oe_bad = 0;
      k = 0;
      host_write(mk(1, 0, 2'b01, phy, rg, d));
      if (try_ignore) begin
         host_write(mk(1, 1, 2'b10, ~phy, ~rg, ~d));
         chk("R4 ignored while busy", cmd_rdata, mk(1, 0, 2'b01, phy, rg, d));
      end
      wait_idle(n);
      if (!try_ignore) chk("R8 busy length", 32'(n), 32'(BUSY_CYC));
      chk_header("R6 write frame", 2'b01, phy, rg, d, FRAME);
      for (int i = 0; i < FRAME; i++) if (cap_oe[i] !== 1'b1) oe_bad++;
      chk("R7 write oe", 32'(oe_bad), 32'd0);
      chk("R7 idle oe", {31'd0, mdio_oe}, 32'd0);
      chk("R5 mdc period", 32'((rise_t[1] - rise_t[0]) / CLK_P), 32'(2 * DIV_HALF));
      chk("R8 data kept", cmd_rdata, mk(0, 0, 2'b01, phy, rg, d));
   endtask

   task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] r,
                         input logic ta, input bit fl_in, input bit fl_exp);
      int n;
      int oe_bad = 0;
      k = 0;
      resp = r;
      ta_val = ta;
      host_write(mk(1, fl_in, 2'b10, phy, rg, 16'h0000));
      wait_idle(n);
      chk("R8 busy length read", 32'(n), 32'(BUSY_CYC));
      chk_header("R6 read header", 2'b10, phy, rg, 16'h0, TA1);
      for (int i = 0; i < FRAME; i++)
         if (cap_oe[i] !== ((i < TA1) ? 1'b1 : 1'b0)) oe_bad++;
      chk("R7 read release", 32'(oe_bad), 32'd0);
      chk("R9 read data", {16'd0, cmd_rdata[15:0]}, {16'd0, r});
      chk("R10 fail flag", {31'd0, cmd_rdata[28]}, {31'd0, fl_exp});
      ta_val = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_bad_op();
      t_write(5'h01, 5'h00, 16'h1140, 0);
      t_write(5'h1F, 5'h1F, 16'hA5C3, 1);
      t_read(5'h03, 5'h02, 16'h600D, 1'b0, 0, 0);
      t_read(5'h07, 5'h11, 16'h8001, 1'b1, 0, 1);
      t_read(5'h07, 5'h11, 16'h3C5A, 1'b0, 1, 1);
      t_read(5'h10, 5'h01, 16'h7FFE, 1'b0, 0, 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule